// File: doc/BRIEF.md
# ATR Daughterboard GPIO Controller

This block drives four banks of 16 general-purpose pins toward daughterboard slots. Software programs each bank through a small write bus. A bank has a plain output register and a direction register, both written with a value and a per-bit write mask. It also has three automatic transmit/receive (ATR) registers: a select mask, a transmit pattern and a receive pattern. Pins selected by the mask follow the transmit pattern while the transmitter is active and the receive pattern otherwise. All other pins follow the plain output register.

The transmit state is derived from a transmit-FIFO-not-empty input. Separate programmable tick counts stretch the entry into and the exit from transmit, so short changes in FIFO occupancy are filtered out. Each bank can also replace pin 0 with a divided copy of the block clock, which serves as a reference clock for the daughterboard. Reading any bank address returns that bank's pin inputs after a two-flop synchroniser.

Top module: `atr_gpio_ctrl`

## Requirements
- R1: After reset every register is zero, so `pin_o`, `pin_oe_o` and `tx_state_o` are all zero.
- R2: A write to the output register (kind 0) uses `bus_wdata_i[31:16]` as a bit mask and `[15:0]` as the value. Only bits whose mask bit is 1 change.
- R3: While the global ATR enable is 0, every pin of a bank shows that bank's output register, whatever its ATR mask holds.
- R4: While the ATR enable is 1, a pin whose ATR mask bit (kind 2) is 1 shows the transmit pattern (kind 3) when `tx_state_o`=1 and the receive pattern (kind 4) when `tx_state_o`=0. A pin whose mask bit is 0 shows the output register.
- R5: `pin_oe_o` equals the direction register (kind 1, 1 = drive). That register is written with the same mask/value format as R2, and `pin_oe_o` changes only on such a write.
- R6: `tx_state_o` rises after the FIFO-not-empty input has been sampled high on rise_delay+1 consecutive clocks. It falls after the input has been sampled low on fall_delay+1 consecutive clocks. The delays are written through kind 7: rise_delay in `[7:0]`, fall_delay in `[15:8]`.
- R7: If the FIFO input returns to the current `tx_state_o` level before the pending delay expires, `tx_state_o` does not change, and the next change of the input starts a fresh count.
- R8: The reference-clock config (kind 5) has its enable in bit 7 and its divisor in bits 6:0. When enabled, pin 0 of the bank starts low and toggles every max(divisor,1)+1 clocks, counted from the write. When disabled, pin 0 behaves as an ordinary pin. Other pins are never affected.
- R9: `bus_rdata_o[15:0]` gives the pin inputs of the bank addressed by `bus_addr_i[1:0]`, as sampled two clock edges earlier. `bus_rdata_o[31:16]` is zero.
- R10: The address field `bus_addr_i[4:2]` selects the register kind and `bus_addr_i[1:0]` selects the bank. The global ATR enable (kind 6, bit 0) and the delay register (kind 7) ignore the bank field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register kind [4:2], bank [1:0] |
| bus_wdata_i | input | 32 | Write data (mask in upper half for output and direction writes) |
| bus_rdata_o | output | 32 | Synchronised pin inputs of the addressed bank |
| tx_fifo_nempty_i | input | 1 | Transmit FIFO holds data |
| pin_i | input | 64 | Pin input values, bank n at [16n+15:16n] |
| pin_o | output | 64 | Pin output values |
| pin_oe_o | output | 64 | Pin output enables |
| tx_state_o | output | 1 | Filtered transmit/receive state |

## Verification
A wrong delay counter shows on `tx_state_o`, and through every ATR-masked pin, on the first clock where the filtered state should or should not have flipped. So a miscount of one tick is visible in the same cycle. A corrupted bank register or a wrong mask merge appears on `pin_o` or `pin_oe_o` the cycle after the offending write. A wrong divider count first shows at the earliest expected toggle of pin 0. A wrong synchroniser depth makes `bus_rdata_o` disagree with the input from two edges back on the first cycle the random pin pattern changes.

// File: rtl/atr_gpio_pkg.sv
package atr_gpio_pkg;
  typedef enum logic [2:0] {
    K_OUT  = 3'd0,
    K_DIR  = 3'd1,
    K_MASK = 3'd2,
    K_TXV  = 3'd3,
    K_RXV  = 3'd4,
    K_RCK  = 3'd5,
    K_CTRL = 3'd6,
    K_DLY  = 3'd7
  } reg_kind_e;
endpackage

// File: rtl/atr_pin_sync.sv
module atr_pin_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/atr_tr_timer.sv
module atr_tr_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_nempty_i,
  input  logic [DLY_W-1:0] rise_dly_i,
  input  logic [DLY_W-1:0] fall_dly_i,
  output logic             tr_o
);
  logic [DLY_W-1:0] cnt_q, lim;
  logic             tr_q;

  assign lim = tr_q ? fall_dly_i : rise_dly_i;

  // count only while input disagrees with state; any agreement restarts the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tr_q  <= 1'b0;
    end else if (fifo_nempty_i == tr_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= lim) begin
      cnt_q <= '0;
      tr_q  <= ~tr_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tr_o = tr_q;
endmodule

// File: rtl/atr_refclk_div.sv
module atr_refclk_div #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);
  logic [DIV_W-1:0] cnt_q, lim;
  logic             clk_q;

  assign lim = (div_i == '0) ? DIV_W'(1) : div_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (cnt_q >= lim) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o = clk_q;
endmodule

// File: rtl/atr_bank.sv
module atr_bank #(
  parameter int BANK_W = 16,
  parameter int DIV_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_out_i,
  input  logic              we_dir_i,
  input  logic              we_msk_i,
  input  logic              we_txv_i,
  input  logic              we_rxv_i,
  input  logic              we_rck_i,
  input  logic [BANK_W-1:0] wval_i,
  input  logic [BANK_W-1:0] wmsk_i,
  input  logic              atr_en_i,
  input  logic              tr_i,
  output logic [BANK_W-1:0] pin_o,
  output logic [BANK_W-1:0] oe_o
);
  logic [BANK_W-1:0] out_q, dir_q, msk_q, txv_q, rxv_q;
  logic              rck_en_q;
  logic [DIV_W-1:0]  rck_div_q;
  logic              rck;
  logic [BANK_W-1:0] atr_val, mixed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q     <= '0;
      dir_q     <= '0;
      msk_q     <= '0;
      txv_q     <= '0;
      rxv_q     <= '0;
      rck_en_q  <= 1'b0;
      rck_div_q <= '0;
    end else begin
      if (we_out_i) out_q <= (out_q & ~wmsk_i) | (wval_i & wmsk_i);
      if (we_dir_i) dir_q <= (dir_q & ~wmsk_i) | (wval_i & wmsk_i);
      if (we_msk_i) msk_q <= wval_i;
      if (we_txv_i) txv_q <= wval_i;
      if (we_rxv_i) rxv_q <= wval_i;
      if (we_rck_i) begin
        rck_en_q  <= wval_i[DIV_W];
        rck_div_q <= wval_i[DIV_W-1:0];
      end
    end
  end

  atr_refclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (rck_en_q),
    .div_i (rck_div_q),
    .clk_o (rck)
  );

  always_comb begin
    atr_val = tr_i ? txv_q : rxv_q;
    mixed   = atr_en_i ? ((out_q & ~msk_q) | (atr_val & msk_q)) : out_q;
    pin_o   = {mixed[BANK_W-1:1], rck_en_q ? rck : mixed[0]};
  end

  assign oe_o = dir_q;
endmodule

// File: rtl/atr_gpio_ctrl.sv
module atr_gpio_ctrl
  import atr_gpio_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int BANK_W    = 16,
  parameter  int DLY_W     = 8,
  parameter  int DIV_W     = 7,
  localparam int BANK_AW   = $clog2(NUM_BANKS),
  localparam int ADDR_W    = BANK_AW + 3,
  localparam int DATA_W    = 2 * BANK_W,
  localparam int PIN_W     = NUM_BANKS * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              tx_fifo_nempty_i,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [PIN_W-1:0]  pin_o,
  output logic [PIN_W-1:0]  pin_oe_o,
  output logic              tx_state_o
);
  reg_kind_e          kind;
  logic [BANK_AW-1:0] bsel;
  logic [BANK_W-1:0]  wval, wmsk;
  logic               atr_en_q;
  logic [DLY_W-1:0]   rise_q, fall_q;
  logic               tr;
  logic [PIN_W-1:0]   pin_sync;

  assign kind = reg_kind_e'(bus_addr_i[ADDR_W-1:BANK_AW]);
  assign bsel = bus_addr_i[BANK_AW-1:0];
  assign wval = bus_wdata_i[BANK_W-1:0];
  assign wmsk = bus_wdata_i[DATA_W-1:BANK_W];

  // global controls ignore the bank field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      atr_en_q <= 1'b0;
      rise_q   <= '0;
      fall_q   <= '0;
    end else if (bus_we_i) begin
      if (kind == K_CTRL) atr_en_q <= bus_wdata_i[0];
      if (kind == K_DLY) begin
        rise_q <= bus_wdata_i[DLY_W-1:0];
        fall_q <= bus_wdata_i[2*DLY_W-1:DLY_W];
      end
    end
  end

  atr_tr_timer #(.DLY_W(DLY_W)) u_tr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_nempty_i(tx_fifo_nempty_i),
    .rise_dly_i   (rise_q),
    .fall_dly_i   (fall_q),
    .tr_o         (tr)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_we_i && (bsel == BANK_AW'(b));
    atr_bank #(.BANK_W(BANK_W), .DIV_W(DIV_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_out_i(hit && kind == K_OUT),
      .we_dir_i(hit && kind == K_DIR),
      .we_msk_i(hit && kind == K_MASK),
      .we_txv_i(hit && kind == K_TXV),
      .we_rxv_i(hit && kind == K_RXV),
      .we_rck_i(hit && kind == K_RCK),
      .wval_i  (wval),
      .wmsk_i  (wmsk),
      .atr_en_i(atr_en_q),
      .tr_i    (tr),
      .pin_o   (pin_o[b*BANK_W +: BANK_W]),
      .oe_o    (pin_oe_o[b*BANK_W +: BANK_W])
    );
  end

  atr_pin_sync #(.W(PIN_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign bus_rdata_o = {{BANK_W{1'b0}}, pin_sync[bsel*BANK_W +: BANK_W]};
  assign tx_state_o  = tr;
endmodule

// File: rtl/atr_gpio_chk.sv
module atr_gpio_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 16,
  parameter int BANK_AW   = 2,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int PIN_W     = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              tx_fifo_nempty_i,
  input logic [PIN_W-1:0]  pin_i,
  input logic [PIN_W-1:0]  pin_oe_o,
  input logic              tx_state_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  function automatic logic [BANK_W-1:0] slice(input logic [PIN_W-1:0] v,
                                               input logic [BANK_AW-1:0] b);
    return v[b*BANK_W +: BANK_W];
  endfunction

  a_r6_rise_needs_fifo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_state_o) |-> $past(tx_fifo_nempty_i));

  a_r6_fall_needs_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_state_o) |-> !$past(tx_fifo_nempty_i));

  a_r5_oe_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_i |=> $stable(pin_oe_o));

  a_r9_two_flop_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |->
      (bus_rdata_o[BANK_W-1:0] == slice($past(pin_i, 2), bus_addr_i[BANK_AW-1:0])));

  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:BANK_W] == '0);
endmodule

bind atr_gpio_ctrl atr_gpio_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .BANK_AW  (BANK_AW),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PIN_W    (PIN_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .bus_we_i        (bus_we_i),
  .bus_addr_i      (bus_addr_i),
  .bus_rdata_o     (bus_rdata_o),
  .tx_fifo_nempty_i(tx_fifo_nempty_i),
  .pin_i           (pin_i),
  .pin_oe_o        (pin_oe_o),
  .tx_state_o      (tx_state_o)
);

// File: tb/sim_atr_gpio_ctrl.sv
`timescale 1ns/1ps
module sim_atr_gpio_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [4:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        fifo = 1'b0;
  logic [63:0] pin_i = '0;
  logic [63:0] pin_o, pin_oe_o;
  logic        tx_state_o;

  always #10 clk_i = ~clk_i;

  atr_gpio_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .tx_fifo_nempty_i(fifo),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .tx_state_o(tx_state_o)
  );

  int checks = 0, errs = 0, cycles = 0;
  string cur_tag = "R1";
  bit run_cmp = 1'b0, done = 1'b0;

  // reference model
  logic [15:0] m_out[4], m_dir[4], m_msk[4], m_txv[4], m_rxv[4], s1[4], s2[4];
  bit          m_ren[4], rc_bit[4];
  int          m_div[4], rc_cnt[4];
  bit          m_atr, m_tr;
  int          m_rise, m_fall, tcnt;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [63:0] exp_pins();
    logic [63:0] r;
    for (int b = 0; b < 4; b++) begin
      logic [15:0] v, a;
      a = m_tr ? m_txv[b] : m_rxv[b];
      v = m_atr ? ((m_out[b] & ~m_msk[b]) | (a & m_msk[b])) : m_out[b];
      if (m_ren[b]) v[0] = rc_bit[b];
      r[b*16 +: 16] = v;
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_oe();
    logic [63:0] r;
    for (int b = 0; b < 4; b++) r[b*16 +: 16] = m_dir[b];
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 4; b++) begin
        m_out[b] = 0; m_dir[b] = 0; m_msk[b] = 0; m_txv[b] = 0; m_rxv[b] = 0;
        s1[b] = 0; s2[b] = 0; m_ren[b] = 0; rc_bit[b] = 0; m_div[b] = 0; rc_cnt[b] = 0;
      end
      m_atr = 0; m_tr = 0; m_rise = 0; m_fall = 0; tcnt = 0;
    end else begin
      int lim;
      lim = m_tr ? m_fall : m_rise;
      if (fifo != m_tr) begin
        if (tcnt >= lim) begin m_tr = !m_tr; tcnt = 0; end
        else tcnt++;
      end else tcnt = 0;
      for (int b = 0; b < 4; b++) begin
        int d;
        d = (m_div[b] == 0) ? 1 : m_div[b];
        if (!m_ren[b]) begin rc_cnt[b] = 0; rc_bit[b] = 0; end
        else if (rc_cnt[b] >= d) begin rc_cnt[b] = 0; rc_bit[b] = !rc_bit[b]; end
        else rc_cnt[b]++;
        s2[b] = s1[b];
        s1[b] = pin_i[b*16 +: 16];
      end
      if (bus_we_i) begin
        int k, b;
        logic [15:0] v, m;
        k = int'(bus_addr_i[4:2]); b = int'(bus_addr_i[1:0]);
        v = bus_wdata_i[15:0]; m = bus_wdata_i[31:16];
        case (k)
          0: m_out[b] = (m_out[b] & ~m) | (v & m);
          1: m_dir[b] = (m_dir[b] & ~m) | (v & m);
          2: m_msk[b] = v;
          3: m_txv[b] = v;
          4: m_rxv[b] = v;
          5: begin m_ren[b] = v[7]; m_div[b] = int'(v[6:0]); end
          6: m_atr = bus_wdata_i[0];
          default: begin m_rise = int'(bus_wdata_i[7:0]); m_fall = int'(bus_wdata_i[15:8]); end
        endcase
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && run_cmp) begin
      chk(cur_tag, pin_o, exp_pins());
      chk("R5", pin_oe_o, exp_oe());
      chk("R6", {63'b0, tx_state_o}, {63'b0, m_tr});
      chk("R9", {32'b0, bus_rdata_o}, {48'b0, s2[bus_addr_i[1:0]]});
    end
  end

  initial begin
    forever begin
      @(posedge clk_i); #2;
      pin_i = {$urandom, $urandom};
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - errs, checks);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  task automatic wr(input int k, input int b, input logic [31:0] d);
    @(posedge clk_i); #2;
    bus_we_i = 1'b1;
    bus_addr_i = {k[2:0], b[1:0]};
    bus_wdata_i = d;
    @(posedge clk_i); #2;
    bus_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic set_fifo(input bit v);
    @(posedge clk_i); #2;
    fifo = v;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", pin_o, 64'h0);
    chk("R1", pin_oe_o, 64'h0);
    chk("R1", {63'b0, tx_state_o}, 64'h0);
    run_cmp = 1'b1;
    idle(3);

    // R2 masked writes to output register; R5 direction register
    cur_tag = "R2";
    wr(0, 0, 32'hFFFF_1234);
    wr(0, 0, 32'h00F0_ABCD);
    wr(0, 1, 32'h0000_FFFF);
    wr(0, 2, 32'hFF00_5A5A);
    wr(1, 0, 32'h0F0F_FFFF);
    wr(1, 3, 32'hFFFF_8001);
    wr(1, 3, 32'h8000_0000);
    for (int b = 0; b < 4; b++) begin
      @(posedge clk_i); #2 bus_addr_i = {3'd0, b[1:0]};
    end
    idle(2);

    // R3 ATR disabled: masks and patterns have no effect
    cur_tag = "R3";
    wr(2, 1, 32'h0000_00FF);
    wr(3, 1, 32'h0000_AAAA);
    wr(4, 1, 32'h0000_5555);
    wr(2, 0, 32'h0000_F00F);
    wr(3, 0, 32'h0000_1111);
    wr(4, 0, 32'h0000_2222);
    set_fifo(1); idle(4); set_fifo(0); idle(4);

    // R10 global regs written with nonzero bank field; R4 ATR mux
    cur_tag = "R10";
    wr(6, 3, 32'h0000_0001);
    wr(7, 2, 32'h0000_0503);
    cur_tag = "R4";
    set_fifo(1); idle(8);
    set_fifo(0); idle(9);

    // R6 exact edge timing with other delays
    cur_tag = "R6";
    wr(7, 0, 32'h0000_0000);
    set_fifo(1); idle(3); set_fifo(0); idle(3);
    wr(7, 1, 32'h0000_0206);
    set_fifo(1); idle(10); set_fifo(0); idle(6);

    // R7 glitches shorter than the delay
    cur_tag = "R7";
    wr(7, 0, 32'h0000_0404);
    set_fifo(1); idle(1); set_fifo(0); idle(2);
    set_fifo(1); idle(3); set_fifo(0); idle(1);
    set_fifo(1); idle(8);
    set_fifo(0); idle(2); set_fifo(1); idle(4);
    set_fifo(0); idle(8);

    // R8 reference clock on pin 0
    cur_tag = "R8";
    wr(0, 2, 32'hFFFF_FFFF);
    wr(5, 2, 32'h0000_0083);
    idle(20);
    wr(5, 2, 32'h0000_0080);
    idle(12);
    wr(5, 0, 32'hFF00_0085);
    set_fifo(1); idle(16); set_fifo(0);
    wr(5, 2, 32'h0000_0003);
    idle(6);
    wr(5, 0, 32'h0000_0000);
    idle(4);

    run_cmp = 1'b0;
    idle(2);
    finish_up();
  end
endmodule